// File: doc/BRIEF.md
# Relocatable Base-Page and Stack Address Unit

This unit forms the memory addresses of an 8-bit processor with a 16-bit address bus. It owns three bytes of state: the page that stands in for the classic zero page, and the high and low bytes of the stack pointer. It also owns one mode flag. The page mode flag chooses how the stack pointer moves. When it is clear, the pointer wraps inside one 256-byte page. When it is set, the two bytes act as one 16-bit pointer that carries and borrows across pages.

The surrounding core sends one request per cycle on a set of strobes. The requests are:
- load the base page;
- load either stack byte;
- switch the wide stack on or off;
- push or pull;
- a base-page access with an 8-bit offset;
- an indexed access that adds an 8-bit index to a 16-bit base.

The unit answers with a registered address and a valid strobe. A wide-stack access takes one extra cycle, and `busy` is high for that cycle. Requests that collide, or that arrive while the unit is busy, are dropped and reported on `err`.

Top module: `bpstk_agu`

## Requirements
- R1: After reset the base page is 0x00, the stack high byte is 0x01, the stack low byte is 0xFF and the wide-stack flag is 0. `addr_vld`, `busy` and `err` are 0, so the first push addresses 0x01FF.
- R2: A base-page access puts {base page, `bp_off`} on `addr` with `addr_vld` high in the cycle after the request.
- R3: A base-page load takes `wr_data`, and every later base-page access uses the new page.
- R4: With the wide stack off, a push addresses {high, low} and then decrements only the low byte (0x00 becomes 0xFF). The high byte is unchanged. The address is valid one cycle after the request.
- R5: With the wide stack off, a pull first increments only the low byte (0xFF becomes 0x00) and then addresses {high, new low}. The address is valid one cycle after the request.
- R6: With the wide stack on, push and pull use the full 16-bit pointer with carry and borrow. For example, a push at 0x0100 leaves 0x00FF, and a pull from 0x00FF addresses 0x0100.
- R7: A wide-stack access sets `busy` and clears `addr_vld` in the cycle after the request. The address is valid in the cycle after that.
- R8: An indexed access puts (`idx_base` + `idx_val`) mod 65536 on `addr`, valid one cycle after the request, whether or not the sum crosses a 256-byte boundary.
- R9: Switching the wide stack on or off leaves the stored stack high and low bytes unchanged.
- R10: Loading the stack high or low byte takes `wr_data`, and later stack accesses use it.
- R11: When more than one request strobe is high in a cycle, all of them are ignored and `err` is high for the next cycle.
- R12: A request that arrives while `busy` is high is ignored and raises `err` in the next cycle. The pending stack address still comes out.
- R13: In a cycle that follows no accepted access request and no busy cycle, `addr_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_ld_base | input | 1 | Load base page from `wr_data` |
| req_ld_sph | input | 1 | Load stack high byte from `wr_data` |
| req_ld_spl | input | 1 | Load stack low byte from `wr_data` |
| req_ext_on | input | 1 | Switch wide stack on |
| req_ext_off | input | 1 | Switch wide stack off |
| req_push | input | 1 | Stack push access |
| req_pull | input | 1 | Stack pull access |
| req_bp | input | 1 | Base-page access |
| req_idx | input | 1 | Indexed access |
| wr_data | input | 8 | Data for register loads |
| bp_off | input | 8 | Offset within the base page |
| idx_base | input | 16 | Base address for an indexed access |
| idx_val | input | 8 | Index for an indexed access |
| addr | output | 16 | Effective address |
| addr_vld | output | 1 | `addr` holds a new address this cycle |
| busy | output | 1 | A wide-stack address is being formed |
| err | output | 1 | A request in the previous cycle was dropped |

## Verification
Base-page, indexed and narrow-stack addresses are due one cycle after the request. The bench drives each request at a falling edge and reads the result at the next falling edge. A wide-stack address is due one cycle later. At that first falling edge the bench checks that `busy` is high and `addr_vld` is low, and it checks the address one falling edge after that. `err` is due one cycle after the dropped request. Register loads and mode changes have no direct output, so the bench checks their effect through a later access.

// File: rtl/bpstk_pkg.sv
package bpstk_pkg;

    localparam int PG_W  = 8;
    localparam int AD_W  = 2 * PG_W;
    localparam int N_REQ = 9;

    // One strobe per command; legal traffic has at most one set.
    typedef struct packed {
        logic ld_base;
        logic ld_sph;
        logic ld_spl;
        logic ext_on;
        logic ext_off;
        logic push;
        logic pull;
        logic bp;
        logic idx;
    } req_t;

    typedef enum logic [1:0] {
        SRC_BP  = 2'd0,
        SRC_IDX = 2'd1,
        SRC_STK = 2'd2
    } src_e;

    // Move the stack pointer one step; narrow mode keeps the high byte.
    function automatic logic [AD_W-1:0] sp_step(input logic [AD_W-1:0] sp,
                                                 input logic wide,
                                                 input logic up);
        logic [AD_W-1:0] full;
        logic [PG_W-1:0] low;
        full = up ? sp + AD_W'(1) : sp - AD_W'(1);
        low  = up ? sp[PG_W-1:0] + PG_W'(1) : sp[PG_W-1:0] - PG_W'(1);
        return wide ? full : {sp[AD_W-1:PG_W], low};
    endfunction

endpackage

// File: rtl/bpstk_cmd_dec.sv
module bpstk_cmd_dec
    import bpstk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  req_t req,
    input  logic busy,
    output req_t go,
    output logic err
);

    localparam int CNT_W = $clog2(N_REQ + 1);

    logic [CNT_W-1:0] n_req;
    logic             any_req;
    logic             legal;

    always_comb begin
        n_req   = CNT_W'($countones(req));
        any_req = (n_req != '0);
        legal   = (n_req <= CNT_W'(1)) && !busy;
        go      = legal ? req : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) err <= 1'b0;
        else     err <= any_req && !legal;
    end

    // R11
    multi_req_err_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(req) > 1) |=> err);

    // R12
    busy_req_err_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && (req != '0)) |=> err);

endmodule

// File: rtl/bpstk_sp.sv
module bpstk_sp
    import bpstk_pkg::*;
#(
    parameter logic [PG_W-1:0] SPH_RST = 8'h01,
    parameter logic [PG_W-1:0] SPL_RST = 8'hFF
)(
    input  logic            clk,
    input  logic            rst,
    input  req_t            go,
    input  logic [PG_W-1:0] wr_data,
    output logic [AD_W-1:0] stk_addr,
    output logic            wide
);

    logic [AD_W-1:0] sp_q;
    logic [AD_W-1:0] sp_dn;
    logic [AD_W-1:0] sp_up;

    always_comb begin
        sp_dn    = sp_step(sp_q, wide, 1'b0);
        sp_up    = sp_step(sp_q, wide, 1'b1);
        // push uses the current pointer, pull the incremented one
        stk_addr = go.pull ? sp_up : sp_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q <= {SPH_RST, SPL_RST};
            wide <= 1'b0;
        end else begin
            if (go.ext_on)  wide <= 1'b1;
            if (go.ext_off) wide <= 1'b0;
            if (go.ld_sph)  sp_q[AD_W-1:PG_W] <= wr_data;
            if (go.ld_spl)  sp_q[PG_W-1:0]    <= wr_data;
            if (go.push)    sp_q <= sp_dn;
            if (go.pull)    sp_q <= sp_up;
        end
    end

    // R4
    narrow_push_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (go.push && !wide) |=> sp_q[AD_W-1:PG_W] == $past(sp_q[AD_W-1:PG_W]));

    // R5
    narrow_pull_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (go.pull && !wide) |=> sp_q[AD_W-1:PG_W] == $past(sp_q[AD_W-1:PG_W]));

    // R6
    wide_push_chk: assert property (@(posedge clk) disable iff (rst)
        (go.push && wide) |=> sp_q == $past(sp_q) - AD_W'(1));

    // R9
    mode_keeps_sp_chk: assert property (@(posedge clk) disable iff (rst)
        (go.ext_on || go.ext_off) |=> $stable(sp_q));

endmodule

// File: rtl/bpstk_out.sv
module bpstk_out
    import bpstk_pkg::*;
#(
    parameter logic [PG_W-1:0] BASE_RST = 8'h00
)(
    input  logic            clk,
    input  logic            rst,
    input  req_t            go,
    input  logic [PG_W-1:0] wr_data,
    input  logic [PG_W-1:0] bp_off,
    input  logic [AD_W-1:0] idx_base,
    input  logic [PG_W-1:0] idx_val,
    input  logic [AD_W-1:0] stk_addr,
    input  logic            wide,
    output logic [AD_W-1:0] addr,
    output logic            addr_vld,
    output logic            busy
);

    logic [PG_W-1:0] base_q;
    logic [AD_W-1:0] pend_q;
    logic [AD_W-1:0] eff;
    src_e            src;
    logic            acc;
    logic            slow;

    always_comb begin
        acc  = go.bp || go.idx || go.push || go.pull;
        src  = go.bp ? SRC_BP : (go.idx ? SRC_IDX : SRC_STK);
        slow = (go.push || go.pull) && wide;
        unique case (src)
            SRC_BP:  eff = {base_q, bp_off};
            SRC_IDX: eff = idx_base + AD_W'(idx_val);
            default: eff = stk_addr;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q   <= BASE_RST;
            pend_q   <= '0;
            addr     <= '0;
            addr_vld <= 1'b0;
            busy     <= 1'b0;
        end else begin
            if (go.ld_base) base_q <= wr_data;
            if (busy) begin
                addr     <= pend_q;
                addr_vld <= 1'b1;
                busy     <= 1'b0;
            end else if (acc && slow) begin
                pend_q   <= eff;
                addr_vld <= 1'b0;
                busy     <= 1'b1;
            end else if (acc) begin
                addr     <= eff;
                addr_vld <= 1'b1;
            end else begin
                addr_vld <= 1'b0;
            end
        end
    end

    // R2
    bp_addr_chk: assert property (@(posedge clk) disable iff (rst)
        go.bp |=> addr_vld && (addr[PG_W-1:0] == $past(bp_off)));

    // R8
    idx_addr_chk: assert property (@(posedge clk) disable iff (rst)
        go.idx |=> addr_vld && (addr == $past(idx_base) + AD_W'($past(idx_val))));

    // R7
    busy_then_vld_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> addr_vld && !busy);

    // R7
    busy_no_vld_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !addr_vld);

endmodule

// File: rtl/bpstk_agu.sv
module bpstk_agu
    import bpstk_pkg::*;
#(
    parameter logic [7:0] BASE_RST = 8'h00,
    parameter logic [7:0] SPH_RST  = 8'h01,
    parameter logic [7:0] SPL_RST  = 8'hFF
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_ld_base,
    input  logic        req_ld_sph,
    input  logic        req_ld_spl,
    input  logic        req_ext_on,
    input  logic        req_ext_off,
    input  logic        req_push,
    input  logic        req_pull,
    input  logic        req_bp,
    input  logic        req_idx,
    input  logic [7:0]  wr_data,
    input  logic [7:0]  bp_off,
    input  logic [15:0] idx_base,
    input  logic [7:0]  idx_val,
    output logic [15:0] addr,
    output logic        addr_vld,
    output logic        busy,
    output logic        err
);

    req_t            req;
    req_t            go;
    logic [AD_W-1:0] stk_addr;
    logic            wide;

    always_comb begin
        req.ld_base = req_ld_base;
        req.ld_sph  = req_ld_sph;
        req.ld_spl  = req_ld_spl;
        req.ext_on  = req_ext_on;
        req.ext_off = req_ext_off;
        req.push    = req_push;
        req.pull    = req_pull;
        req.bp      = req_bp;
        req.idx     = req_idx;
    end

    bpstk_cmd_dec u_dec (
        .clk  (clk),
        .rst  (rst),
        .req  (req),
        .busy (busy),
        .go   (go),
        .err  (err)
    );

    bpstk_sp #(.SPH_RST(SPH_RST), .SPL_RST(SPL_RST)) u_sp (
        .clk      (clk),
        .rst      (rst),
        .go       (go),
        .wr_data  (wr_data),
        .stk_addr (stk_addr),
        .wide     (wide)
    );

    bpstk_out #(.BASE_RST(BASE_RST)) u_out (
        .clk      (clk),
        .rst      (rst),
        .go       (go),
        .wr_data  (wr_data),
        .bp_off   (bp_off),
        .idx_base (idx_base),
        .idx_val  (idx_val),
        .stk_addr (stk_addr),
        .wide     (wide),
        .addr     (addr),
        .addr_vld (addr_vld),
        .busy     (busy)
    );

    // R13
    idle_no_vld_chk: assert property (@(posedge clk) disable iff (rst)
        (!req_push && !req_pull && !req_bp && !req_idx && !busy) |=> !addr_vld);

endmodule

// File: tb/tb_bpstk_agu.sv
module tb_bpstk_agu;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_ld_base = 0, req_ld_sph = 0, req_ld_spl = 0;
    logic        req_ext_on = 0, req_ext_off = 0, req_push = 0, req_pull = 0;
    logic        req_bp = 0, req_idx = 0;
    logic [7:0]  wr_data = 0, bp_off = 0, idx_val = 0;
    logic [15:0] idx_base = 0;
    logic [15:0] addr;
    logic        addr_vld, busy, err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model
    logic [7:0]  m_base;
    logic [15:0] m_sp;
    logic        m_wide;

    always #(CLK_PERIOD/2) clk = ~clk;

    bpstk_agu dut (
        .clk(clk), .rst(rst),
        .req_ld_base(req_ld_base), .req_ld_sph(req_ld_sph), .req_ld_spl(req_ld_spl),
        .req_ext_on(req_ext_on), .req_ext_off(req_ext_off),
        .req_push(req_push), .req_pull(req_pull), .req_bp(req_bp), .req_idx(req_idx),
        .wr_data(wr_data), .bp_off(bp_off), .idx_base(idx_base), .idx_val(idx_val),
        .addr(addr), .addr_vld(addr_vld), .busy(busy), .err(err)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [15:0] m_step(input logic [15:0] sp, input logic w, input logic up);
        logic [7:0] lo;
        if (w) return up ? sp + 16'd1 : sp - 16'd1;
        lo = up ? sp[7:0] + 8'd1 : sp[7:0] - 8'd1;
        return {sp[15:8], lo};
    endfunction

    task automatic clear_req();
        req_ld_base = 0; req_ld_sph = 0; req_ld_spl = 0; req_ext_on = 0;
        req_ext_off = 0; req_push = 0; req_pull = 0; req_bp = 0; req_idx = 0;
    endtask

    task automatic set_req(input int k);
        case (k)
            0: req_ld_base = 1;
            1: req_ld_sph  = 1;
            2: req_ld_spl  = 1;
            3: req_ext_on  = 1;
            4: req_ext_off = 1;
            5: req_push    = 1;
            6: req_pull    = 1;
            7: req_bp      = 1;
            default: req_idx = 1;
        endcase
    endtask

    // Drive one legal command at a falling edge and check its result.
    task automatic run(input int k, input logic [7:0] d, input logic [15:0] ib,
                       input logic [7:0] ix, input string tag);
        logic [15:0] exp;
        logic        slow;
        exp  = 16'h0;
        slow = 1'b0;
        wr_data = d; bp_off = d; idx_base = ib; idx_val = ix;
        set_req(k);
        case (k)
            0: m_base = d;
            1: m_sp[15:8] = d;
            2: m_sp[7:0] = d;
            3: m_wide = 1'b1;
            4: m_wide = 1'b0;
            5: begin exp = m_sp; slow = m_wide; m_sp = m_step(m_sp, m_wide, 1'b0); end
            6: begin m_sp = m_step(m_sp, m_wide, 1'b1); exp = m_sp; slow = m_wide; end
            7: exp = {m_base, d};
            default: exp = ib + 16'(ix);
        endcase
        @(negedge clk);
        clear_req();
        chk({tag, " err"}, err, 0);
        if (k < 5) begin
            chk({tag, " R13 vld"}, addr_vld, 0);
        end else if (slow) begin
            chk({tag, " R7 busy"}, busy, 1);
            chk({tag, " R7 vld low"}, addr_vld, 0);
            @(negedge clk);
            chk({tag, " R7 vld"}, addr_vld, 1);
            chk({tag, " addr"}, addr, exp);
        end else begin
            chk({tag, " vld"}, addr_vld, 1);
            chk({tag, " addr"}, addr, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_base = 8'h00; m_sp = 16'h01FF; m_wide = 1'b0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1 vld", addr_vld, 0);
        chk("R1 busy", busy, 0);
        chk("R1 err", err, 0);
        run(7, 8'h34, 16'h0, 8'h0, "R1 R2 base reset page");
        run(5, 8'h00, 16'h0, 8'h0, "R1 R4 first push");
        run(6, 8'h00, 16'h0, 8'h0, "R5 pull back");
        // R3 relocate base page
        run(0, 8'hC3, 16'h0, 8'h0, "R3 load");
        run(7, 8'h10, 16'h0, 8'h0, "R3 R2 base access");
        // R4/R5 narrow wrap
        run(2, 8'h00, 16'h0, 8'h0, "R10 ld low");
        run(1, 8'h40, 16'h0, 8'h0, "R10 ld high");
        run(5, 8'h00, 16'h0, 8'h0, "R4 R10 push at 4000");
        run(5, 8'h00, 16'h0, 8'h0, "R4 wrap keeps high 40FF");
        run(6, 8'h00, 16'h0, 8'h0, "R5 pull");
        run(6, 8'h00, 16'h0, 8'h0, "R5 wrap to 4000");
        // R9 mode switch keeps pointer, R6 borrow/carry
        run(2, 8'h00, 16'h0, 8'h0, "R10 ld low");
        run(1, 8'h01, 16'h0, 8'h0, "R10 ld high");
        run(3, 8'h00, 16'h0, 8'h0, "R9 ext on");
        run(5, 8'h00, 16'h0, 8'h0, "R6 R9 push at 0100");
        run(5, 8'h00, 16'h0, 8'h0, "R6 borrow 00FF");
        run(6, 8'h00, 16'h0, 8'h0, "R6 pull");
        run(6, 8'h00, 16'h0, 8'h0, "R6 carry 0100");
        run(4, 8'h00, 16'h0, 8'h0, "R9 ext off");
        run(5, 8'h00, 16'h0, 8'h0, "R9 R4 push after off");
        // R8 indexed
        run(8, 8'h00, 16'h12F0, 8'h20, "R8 cross page");
        run(8, 8'h00, 16'h1200, 8'h05, "R8 same page");
        run(8, 8'h00, 16'hFFF0, 8'h20, "R8 wrap 16 bit");
        // R11 two strobes
        wr_data = 8'h77; bp_off = 8'h77;
        req_ld_base = 1; req_bp = 1;
        @(negedge clk);
        clear_req();
        chk("R11 err", err, 1);
        chk("R11 vld", addr_vld, 0);
        run(7, 8'h01, 16'h0, 8'h0, "R11 base unchanged");
        // R12 request while busy
        run(3, 8'h00, 16'h0, 8'h0, "R12 ext on");
        req_push = 1;
        @(negedge clk);
        clear_req();
        chk("R12 busy", busy, 1);
        req_bp = 1; bp_off = 8'h55;
        @(negedge clk);
        clear_req();
        chk("R12 stack addr vld", addr_vld, 1);
        chk("R12 stack addr", addr, m_sp);
        m_sp = m_step(m_sp, 1'b1, 1'b0);
        chk("R12 err", err, 1);
        @(negedge clk);
        chk("R12 dropped access vld", addr_vld, 0);
        chk("R12 err clears", err, 0);
        // random mix
        for (int i = 0; i < 1500; i++) begin
            int k;
            k = int'($urandom_range(0, 99));
            k = (k < 4) ? 0 : (k < 8) ? 1 : (k < 12) ? 2 : (k < 18) ? 3 :
                (k < 24) ? 4 : (k < 44) ? 5 : (k < 64) ? 6 : (k < 82) ? 7 : 8;
            run(k, 8'($urandom), 16'($urandom), 8'($urandom), "rand R2 R4 R5 R6 R8");
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule